// File: doc/BRIEF.md
# AC-link Tag and Command Slot Checker

This block sits behind an AC-link deserializer and receives whole slot words, with one stream for each link direction. For each direction it decodes three slots. The tag slot (index 0) gives codec readiness, the codec ID and a twelve-bit mask. The mask says which of the later slots in the current frame carry data. The address slot (index 1) and the data slot (index 2) are decoded only when the tag of the same frame marks them valid. The block also flags protocol violations: reserved bits that are set, and register addresses that are odd.

The field layout of slot 1 differs between the controller-to-codec (outbound) and codec-to-controller (inbound) directions. Outbound, slot 1 holds a read/write flag. Inbound, it holds ten data-request flags. A register access is reported as a one-cycle strobe only when slot 1 and slot 2 were both accepted within one frame. A shared `frame_start` pulse marks each frame boundary and clears the per-frame state of both directions.

Top module: `aclink_slot_checker`

## Requirements
- R1: A word with index 0 is always accepted as the tag. Bit 15 of the word drives `*_ready`, bits 1..0 drive `*_codec`, and `*_vmask[k-1]` takes tag bit 15-k for slots k = 1..12. Word bits 19..16 are ignored for the tag. All of these are visible one clock after the word.
- R2: A word with index k in 1..12 has no effect unless `*_vmask[k-1]` is set in the current frame. Before the frame's tag arrives the mask is zero. Indices 13..15 are always ignored.
- R3: An accepted tag with bit 2 set raises `*_err_rsv`.
- R4: Outbound slot 1 is decoded as follows. Bit 19 is the read flag (1 = read) and bits 18..12 are the register address. Any set bit in 11..0 raises `ob_err_rsv`.
- R5: Inbound slot 1 is decoded as follows. Bits 18..12 are the address and bits 11..2 are the request flags. A set bit 19, or a set bit in 1..0, raises `ib_err_rsv`.
- R6: An accepted slot 1 whose address has bit 0 set raises `*_err_odd`.
- R7: Slot 2 bits 19..4 are the register data. Any set bit in 3..0 of an accepted slot 2 raises `*_err_rsv`.
- R8: One clock after an accepted slot 2, `*_cmd_vld` is high for one cycle if slot 1 was accepted earlier in the same frame. It carries that slot 1's address and flag fields together with the slot 2 data.
- R9: An accepted slot 2 with no accepted slot 1 in the same frame produces no strobe, even if slot 1 was accepted in an earlier frame.
- R10: Error flags stay set until `frame_start`. After `frame_start`, the flags, ready, codec ID and mask all read zero. A word presented in the same cycle as `frame_start` belongs to the new frame.
- R11: The two directions are independent. Words on one stream never change the outputs of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse at each frame boundary |
| ob_slot_vld | input | 1 | Outbound slot word present |
| ob_slot_idx | input | IDX_W | Outbound slot index |
| ob_slot_word | input | SLOT_W | Outbound slot word, MSB first on the wire |
| ib_slot_vld | input | 1 | Inbound slot word present |
| ib_slot_idx | input | IDX_W | Inbound slot index |
| ib_slot_word | input | SLOT_W | Inbound slot word |
| ob_ready | output | 1 | Outbound tag ready bit |
| ob_codec | output | ID_W | Outbound codec ID |
| ob_vmask | output | NUM_VSLOTS | Outbound valid mask, bit k-1 for slot k |
| ob_err_rsv | output | 1 | Outbound reserved-bit error, sticky for the frame |
| ob_err_odd | output | 1 | Outbound odd-address error, sticky for the frame |
| ob_cmd_vld | output | 1 | Outbound command strobe |
| ob_cmd_rd | output | 1 | Outbound read flag |
| ob_cmd_addr | output | ADDR_W | Outbound register address |
| ob_cmd_data | output | DATA_W | Outbound register data |
| ib_ready | output | 1 | Inbound tag ready bit |
| ib_codec | output | ID_W | Inbound codec ID |
| ib_vmask | output | NUM_VSLOTS | Inbound valid mask |
| ib_err_rsv | output | 1 | Inbound reserved-bit error |
| ib_err_odd | output | 1 | Inbound odd-address error |
| ib_cmd_vld | output | 1 | Inbound status strobe |
| ib_cmd_req | output | REQ_W | Inbound data-request flags |
| ib_cmd_addr | output | ADDR_W | Inbound register address |
| ib_cmd_data | output | DATA_W | Inbound register data |

## Verification
The bench builds the block with its default parameters: 20-bit slot words, a 7-bit address, 16-bit data, 10 request flags and a 12-slot mask. The index is therefore 4 bits wide. With this index width the bench can present the unassigned indices 13 to 15 as well as every maskable slot. It can also reach both generate variants of the slot 1 decoder in one build. Random frames mix set and cleared reserved bits, odd addresses, and masks with slots 1 and 2 present or absent. Directed frames cover a slot word that arrives before its tag, and an address left over from a previous frame.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
   localparam int unsigned SLOT_TAG  = 0;
   localparam int unsigned SLOT_ADDR = 1;
   localparam int unsigned SLOT_DATA = 2;

   typedef enum logic {
      DIR_OUT = 1'b0,
      DIR_IN  = 1'b1
   } acl_dir_e;
endpackage

// File: rtl/acl_tag_fields.sv
module acl_tag_fields #(
   parameter int unsigned NUM_VSLOTS = 12,
   parameter int unsigned ID_W       = 2,
   parameter int unsigned TAG_W      = NUM_VSLOTS + ID_W + 2
) (
   input  logic [TAG_W-1:0]      tag,
   output logic                  ready,
   output logic [NUM_VSLOTS-1:0] vmask,
   output logic                  rsv_hit,
   output logic [ID_W-1:0]       codec
);
   assign ready   = tag[TAG_W-1];
   assign rsv_hit = tag[ID_W];
   assign codec   = tag[ID_W-1:0];

   // slot k (k >= 1) is flagged by tag bit TAG_W-1-k
   for (genvar k = 0; k < NUM_VSLOTS; k++) begin : g_vbit
      assign vmask[k] = tag[TAG_W-2-k];
   end
endmodule

// File: rtl/acl_addr_fields.sv
module acl_addr_fields
   import aclink_pkg::*;
#(
   parameter int unsigned SLOT_W = 20,
   parameter int unsigned ADDR_W = 7,
   parameter int unsigned REQ_W  = 10,
   parameter acl_dir_e    DIR    = DIR_OUT,
   parameter int unsigned FLAG_W = 1
) (
   input  logic [SLOT_W-1:0] word,
   output logic [ADDR_W-1:0] addr,
   output logic [FLAG_W-1:0] flags,
   output logic              rsv_hit,
   output logic              odd
);
   localparam int unsigned ADDR_LSB = SLOT_W - 1 - ADDR_W;
   localparam int unsigned LOW_RSV  = ADDR_LSB - REQ_W;

   assign addr = word[SLOT_W-2 -: ADDR_W];
   assign odd  = addr[0];

   if (DIR == DIR_OUT) begin : g_outbound
      assign flags   = FLAG_W'(word[SLOT_W-1]);
      assign rsv_hit = |word[ADDR_LSB-1:0];
   end else begin : g_inbound
      assign flags   = FLAG_W'(word[ADDR_LSB-1 -: REQ_W]);
      assign rsv_hit = word[SLOT_W-1] | (|word[LOW_RSV-1:0]);
   end
endmodule

// File: rtl/acl_data_fields.sv
module acl_data_fields #(
   parameter int unsigned SLOT_W = 20,
   parameter int unsigned DATA_W = 16
) (
   input  logic [SLOT_W-1:0] word,
   output logic [DATA_W-1:0] data,
   output logic              rsv_hit
);
   assign data    = word[SLOT_W-1 -: DATA_W];
   assign rsv_hit = |word[SLOT_W-DATA_W-1:0];
endmodule

// File: rtl/acl_lane.sv
module acl_lane
   import aclink_pkg::*;
#(
   parameter int unsigned SLOT_W     = 20,
   parameter int unsigned ADDR_W     = 7,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned REQ_W      = 10,
   parameter int unsigned ID_W       = 2,
   parameter int unsigned NUM_VSLOTS = 12,
   parameter int unsigned IDX_W      = 4,
   parameter acl_dir_e    DIR        = DIR_OUT,
   parameter int unsigned FLAG_W     = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  frame_start,
   input  logic                  s_vld,
   input  logic [IDX_W-1:0]      s_idx,
   input  logic [SLOT_W-1:0]     s_word,
   output logic                  ready,
   output logic [ID_W-1:0]       codec,
   output logic [NUM_VSLOTS-1:0] vmask,
   output logic                  err_rsv,
   output logic                  err_odd,
   output logic                  cmd_vld,
   output logic [FLAG_W-1:0]     cmd_flags,
   output logic [ADDR_W-1:0]     cmd_addr,
   output logic [DATA_W-1:0]     cmd_data
);
   localparam int unsigned TAG_W = NUM_VSLOTS + ID_W + 2;

   logic                  t_ready, t_rsv;
   logic [NUM_VSLOTS-1:0] t_mask;
   logic [ID_W-1:0]       t_codec;
   logic [ADDR_W-1:0]     a_addr;
   logic [FLAG_W-1:0]     a_flags;
   logic                  a_rsv, a_odd;
   logic [DATA_W-1:0]     d_data;
   logic                  d_rsv;

   acl_tag_fields #(.NUM_VSLOTS(NUM_VSLOTS), .ID_W(ID_W), .TAG_W(TAG_W)) u_tag (
      .tag(s_word[TAG_W-1:0]), .ready(t_ready), .vmask(t_mask),
      .rsv_hit(t_rsv), .codec(t_codec)
   );

   acl_addr_fields #(.SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .REQ_W(REQ_W),
                     .DIR(DIR), .FLAG_W(FLAG_W)) u_addr (
      .word(s_word), .addr(a_addr), .flags(a_flags), .rsv_hit(a_rsv), .odd(a_odd)
   );

   acl_data_fields #(.SLOT_W(SLOT_W), .DATA_W(DATA_W)) u_data (
      .word(s_word), .data(d_data), .rsv_hit(d_rsv)
   );

   logic [NUM_VSLOTS-1:0] mask_q, base_mask;
   logic                  ready_q, base_ready;
   logic [ID_W-1:0]       codec_q, base_codec;
   logic                  have_q, base_have;
   logic                  rsv_q, base_rsv;
   logic                  odd_q, base_odd;
   logic [ADDR_W-1:0]     addr_q;
   logic [FLAG_W-1:0]     flags_q;
   logic                  hit_tag, hit_addr, hit_data, fire;
   logic                  vld_q;
   logic [FLAG_W-1:0]     cflags_q;
   logic [ADDR_W-1:0]     caddr_q;
   logic [DATA_W-1:0]     cdata_q;

   // a word in the frame_start cycle is judged against the cleared state
   always_comb begin
      base_mask  = frame_start ? '0   : mask_q;
      base_ready = frame_start ? 1'b0 : ready_q;
      base_codec = frame_start ? '0   : codec_q;
      base_have  = frame_start ? 1'b0 : have_q;
      base_rsv   = frame_start ? 1'b0 : rsv_q;
      base_odd   = frame_start ? 1'b0 : odd_q;
      hit_tag    = s_vld && (s_idx == IDX_W'(SLOT_TAG));
      hit_addr   = s_vld && (s_idx == IDX_W'(SLOT_ADDR)) && base_mask[SLOT_ADDR-1];
      hit_data   = s_vld && (s_idx == IDX_W'(SLOT_DATA)) && base_mask[SLOT_DATA-1];
      fire       = hit_data && base_have;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q   <= '0;
         ready_q  <= 1'b0;
         codec_q  <= '0;
         have_q   <= 1'b0;
         rsv_q    <= 1'b0;
         odd_q    <= 1'b0;
         addr_q   <= '0;
         flags_q  <= '0;
         vld_q    <= 1'b0;
         cflags_q <= '0;
         caddr_q  <= '0;
         cdata_q  <= '0;
      end else begin
         mask_q  <= hit_tag ? t_mask  : base_mask;
         ready_q <= hit_tag ? t_ready : base_ready;
         codec_q <= hit_tag ? t_codec : base_codec;
         have_q  <= hit_addr | base_have;
         rsv_q   <= base_rsv | (hit_tag & t_rsv) | (hit_addr & a_rsv) | (hit_data & d_rsv);
         odd_q   <= base_odd | (hit_addr & a_odd);
         if (hit_addr) begin
            addr_q  <= a_addr;
            flags_q <= a_flags;
         end
         vld_q <= fire;
         if (fire) begin
            cflags_q <= flags_q;
            caddr_q  <= addr_q;
            cdata_q  <= d_data;
         end
      end
   end

   assign ready     = ready_q;
   assign codec     = codec_q;
   assign vmask     = mask_q;
   assign err_rsv   = rsv_q;
   assign err_odd   = odd_q;
   assign cmd_vld   = vld_q;
   assign cmd_flags = cflags_q;
   assign cmd_addr  = caddr_q;
   assign cmd_data  = cdata_q;
endmodule

// File: rtl/aclink_slot_checker.sv
module aclink_slot_checker
   import aclink_pkg::*;
#(
   parameter int unsigned SLOT_W     = 20,
   parameter int unsigned ADDR_W     = 7,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned REQ_W      = 10,
   parameter int unsigned ID_W       = 2,
   parameter int unsigned NUM_VSLOTS = 12,
   localparam int unsigned IDX_W     = $clog2(NUM_VSLOTS + 1),
   localparam int unsigned TAG_W     = NUM_VSLOTS + ID_W + 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  frame_start,
   input  logic                  ob_slot_vld,
   input  logic [IDX_W-1:0]      ob_slot_idx,
   input  logic [SLOT_W-1:0]     ob_slot_word,
   input  logic                  ib_slot_vld,
   input  logic [IDX_W-1:0]      ib_slot_idx,
   input  logic [SLOT_W-1:0]     ib_slot_word,
   output logic                  ob_ready,
   output logic [ID_W-1:0]       ob_codec,
   output logic [NUM_VSLOTS-1:0] ob_vmask,
   output logic                  ob_err_rsv,
   output logic                  ob_err_odd,
   output logic                  ob_cmd_vld,
   output logic                  ob_cmd_rd,
   output logic [ADDR_W-1:0]     ob_cmd_addr,
   output logic [DATA_W-1:0]     ob_cmd_data,
   output logic                  ib_ready,
   output logic [ID_W-1:0]       ib_codec,
   output logic [NUM_VSLOTS-1:0] ib_vmask,
   output logic                  ib_err_rsv,
   output logic                  ib_err_odd,
   output logic                  ib_cmd_vld,
   output logic [REQ_W-1:0]      ib_cmd_req,
   output logic [ADDR_W-1:0]     ib_cmd_addr,
   output logic [DATA_W-1:0]     ib_cmd_data
);
   if (ADDR_W + REQ_W + 3 != SLOT_W) begin : g_bad_slot1
      initial $fatal(1, "slot 1 fields do not fill the slot word");
   end
   if (DATA_W >= SLOT_W) begin : g_bad_slot2
      initial $fatal(1, "slot 2 needs at least one reserved bit");
   end
   if (TAG_W > SLOT_W || NUM_VSLOTS < 2) begin : g_bad_tag
      initial $fatal(1, "tag layout does not fit the slot word");
   end

   acl_lane #(.SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REQ_W(REQ_W),
              .ID_W(ID_W), .NUM_VSLOTS(NUM_VSLOTS), .IDX_W(IDX_W),
              .DIR(DIR_OUT), .FLAG_W(1)) u_ob (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .s_vld(ob_slot_vld), .s_idx(ob_slot_idx), .s_word(ob_slot_word),
      .ready(ob_ready), .codec(ob_codec), .vmask(ob_vmask),
      .err_rsv(ob_err_rsv), .err_odd(ob_err_odd), .cmd_vld(ob_cmd_vld),
      .cmd_flags(ob_cmd_rd), .cmd_addr(ob_cmd_addr), .cmd_data(ob_cmd_data)
   );

   acl_lane #(.SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REQ_W(REQ_W),
              .ID_W(ID_W), .NUM_VSLOTS(NUM_VSLOTS), .IDX_W(IDX_W),
              .DIR(DIR_IN), .FLAG_W(REQ_W)) u_ib (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .s_vld(ib_slot_vld), .s_idx(ib_slot_idx), .s_word(ib_slot_word),
      .ready(ib_ready), .codec(ib_codec), .vmask(ib_vmask),
      .err_rsv(ib_err_rsv), .err_odd(ib_err_odd), .cmd_vld(ib_cmd_vld),
      .cmd_flags(ib_cmd_req), .cmd_addr(ib_cmd_addr), .cmd_data(ib_cmd_data)
   );
endmodule

// File: rtl/acl_slot_checker_sva.sv
module acl_slot_checker_sva #(
   parameter int unsigned IDX_W      = 4,
   parameter int unsigned SLOT_W     = 20,
   parameter int unsigned NUM_VSLOTS = 12
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  frame_start,
   input logic                  ob_slot_vld,
   input logic [IDX_W-1:0]      ob_slot_idx,
   input logic                  ib_slot_vld,
   input logic [IDX_W-1:0]      ib_slot_idx,
   input logic [NUM_VSLOTS-1:0] ob_vmask,
   input logic                  ob_err_rsv,
   input logic                  ob_err_odd,
   input logic                  ob_cmd_vld,
   input logic [NUM_VSLOTS-1:0] ib_vmask,
   input logic                  ib_err_rsv,
   input logic                  ib_err_odd,
   input logic                  ib_cmd_vld
);
   // R8
   ob_cmd_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ob_cmd_vld |-> $past(ob_slot_vld && ob_slot_idx == IDX_W'(2)));
   // R8
   ib_cmd_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ib_cmd_vld |-> $past(ib_slot_vld && ib_slot_idx == IDX_W'(2)));
   // R6
   ob_odd_from_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ob_err_odd) |-> $past(ob_slot_vld && ob_slot_idx == IDX_W'(1)));
   // R6
   ib_odd_from_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ib_err_odd) |-> $past(ib_slot_vld && ib_slot_idx == IDX_W'(1)));
   // R10
   ob_frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && !ob_slot_vld) |=> (!ob_err_rsv && !ob_err_odd && ob_vmask == '0));
   // R10
   ib_frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && !ib_slot_vld) |=> (!ib_err_rsv && !ib_err_odd && ib_vmask == '0));
   // R10
   ob_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ob_err_rsv && !frame_start) |=> ob_err_rsv);
   // R2
   ob_mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_start && !(ob_slot_vld && ob_slot_idx == IDX_W'(0))) |=> $stable(ob_vmask));
   // R11
   ib_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_start && !ib_slot_vld) |=> ($stable(ib_vmask) && $stable(ib_err_rsv) && !ib_cmd_vld));
endmodule

bind aclink_slot_checker acl_slot_checker_sva #(
   .IDX_W(IDX_W), .SLOT_W(SLOT_W), .NUM_VSLOTS(NUM_VSLOTS)
) u_sva (.*);

// File: tb/tb_aclink_slot_checker.sv
`timescale 1ns/1ps
module tb_aclink_slot_checker;
   localparam int SW = 20, AW = 7, DW = 16, RW = 10, IW = 2, NV = 12, XW = 4;

   logic clk = 1'b0, rst_n = 1'b0, frame_start = 1'b0;
   logic ob_slot_vld = 1'b0, ib_slot_vld = 1'b0;
   logic [XW-1:0] ob_slot_idx = '0, ib_slot_idx = '0;
   logic [SW-1:0] ob_slot_word = '0, ib_slot_word = '0;
   logic ob_ready, ob_err_rsv, ob_err_odd, ob_cmd_vld, ob_cmd_rd;
   logic ib_ready, ib_err_rsv, ib_err_odd, ib_cmd_vld;
   logic [IW-1:0] ob_codec, ib_codec;
   logic [NV-1:0] ob_vmask, ib_vmask;
   logic [AW-1:0] ob_cmd_addr, ib_cmd_addr;
   logic [DW-1:0] ob_cmd_data, ib_cmd_data;
   logic [RW-1:0] ib_cmd_req;

   always #2 clk = ~clk;

   aclink_slot_checker dut (.*);

   int checks = 0, failures = 0;

   // reference model, index 0 = outbound, 1 = inbound
   logic [NV-1:0] m_mask [2];
   logic          m_ready [2], m_rsv [2], m_odd [2], m_have [2], m_cmd [2];
   logic [IW-1:0] m_codec [2];
   logic [AW-1:0] m_addr [2], e_addr [2];
   logic [RW-1:0] m_flags [2], e_flags [2];
   logic [DW-1:0] e_data [2];

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic void model_clear(int d);
      m_mask[d] = '0; m_ready[d] = 1'b0; m_codec[d] = '0;
      m_rsv[d] = 1'b0; m_odd[d] = 1'b0; m_have[d] = 1'b0; m_cmd[d] = 1'b0;
   endfunction

   function automatic void model_word(int d, int idx, logic [SW-1:0] w);
      logic acc;
      acc = (idx == 0) || (idx >= 1 && idx <= NV && m_mask[d][idx-1]);
      if (!acc) return;
      if (idx == 0) begin
         m_ready[d] = w[15];
         m_codec[d] = w[1:0];
         for (int k = 1; k <= NV; k++) m_mask[d][k-1] = w[15-k];
         if (w[2]) m_rsv[d] = 1'b1;
      end else if (idx == 1) begin
         m_addr[d] = w[18:12];
         if (d == 0) begin
            m_flags[d] = {9'd0, w[19]};
            if (w[11:0] != 0) m_rsv[d] = 1'b1;
         end else begin
            m_flags[d] = w[11:2];
            if (w[19] || w[1:0] != 0) m_rsv[d] = 1'b1;
         end
         if (w[12]) m_odd[d] = 1'b1;
         m_have[d] = 1'b1;
      end else if (idx == 2) begin
         if (w[3:0] != 0) m_rsv[d] = 1'b1;
         if (m_have[d]) begin
            m_cmd[d] = 1'b1; e_addr[d] = m_addr[d];
            e_flags[d] = m_flags[d]; e_data[d] = w[19:4];
         end
      end
   endfunction

   task automatic check_dir(int d);
      string s;
      s = (d == 0) ? "ob" : "ib";
      if (d == 0) begin
         chk({"R1 R11 ready ", s}, 32'(ob_ready), 32'(m_ready[0]));
         chk({"R1 R11 codec ", s}, 32'(ob_codec), 32'(m_codec[0]));
         chk({"R1 R2 vmask ", s}, 32'(ob_vmask), 32'(m_mask[0]));
         chk({"R3 R4 R7 R10 err_rsv ", s}, 32'(ob_err_rsv), 32'(m_rsv[0]));
         chk({"R6 R10 err_odd ", s}, 32'(ob_err_odd), 32'(m_odd[0]));
         chk({"R8 R9 cmd_vld ", s}, 32'(ob_cmd_vld), 32'(m_cmd[0]));
         if (m_cmd[0]) begin
            chk("R4 R8 cmd_rd ob", 32'(ob_cmd_rd), 32'(e_flags[0][0]));
            chk("R4 R8 cmd_addr ob", 32'(ob_cmd_addr), 32'(e_addr[0]));
            chk("R7 R8 cmd_data ob", 32'(ob_cmd_data), 32'(e_data[0]));
         end
      end else begin
         chk({"R1 R11 ready ", s}, 32'(ib_ready), 32'(m_ready[1]));
         chk({"R1 R11 codec ", s}, 32'(ib_codec), 32'(m_codec[1]));
         chk({"R1 R2 vmask ", s}, 32'(ib_vmask), 32'(m_mask[1]));
         chk({"R3 R5 R7 R10 err_rsv ", s}, 32'(ib_err_rsv), 32'(m_rsv[1]));
         chk({"R6 R10 err_odd ", s}, 32'(ib_err_odd), 32'(m_odd[1]));
         chk({"R8 R9 cmd_vld ", s}, 32'(ib_cmd_vld), 32'(m_cmd[1]));
         if (m_cmd[1]) begin
            chk("R5 R8 cmd_req ib", 32'(ib_cmd_req), 32'(e_flags[1]));
            chk("R5 R8 cmd_addr ib", 32'(ib_cmd_addr), 32'(e_addr[1]));
            chk("R7 R8 cmd_data ib", 32'(ib_cmd_data), 32'(e_data[1]));
         end
      end
   endtask

   task automatic push(int d, int idx, logic [SW-1:0] w);
      @(negedge clk);
      if (d == 0) begin
         ob_slot_vld = 1'b1; ob_slot_idx = XW'(idx); ob_slot_word = w;
      end else begin
         ib_slot_vld = 1'b1; ib_slot_idx = XW'(idx); ib_slot_word = w;
      end
      m_cmd[0] = 1'b0; m_cmd[1] = 1'b0;
      model_word(d, idx, w);
      @(negedge clk);
      ob_slot_vld = 1'b0; ib_slot_vld = 1'b0;
      check_dir(0);
      check_dir(1);
      m_cmd[0] = 1'b0; m_cmd[1] = 1'b0;
   endtask

   task automatic new_frame();
      @(negedge clk);
      frame_start = 1'b1;
      model_clear(0); model_clear(1);
      @(negedge clk);
      frame_start = 1'b0;
      check_dir(0);   // R10
      check_dir(1);
   endtask

   function automatic logic [SW-1:0] tag_word(logic rdy, logic [NV-1:0] vm, logic rsv, logic [1:0] id);
      logic [SW-1:0] w;
      w = '0; w[15] = rdy; w[2] = rsv; w[1:0] = id;
      for (int k = 1; k <= NV; k++) w[15-k] = vm[k-1];
      return w;
   endfunction

   function automatic logic [SW-1:0] tidy(int d, int idx, logic [SW-1:0] w);
      logic [SW-1:0] r;
      r = w;
      if (idx == 0) begin r[19:16] = '0; r[2] = 1'b0; end
      else if (idx == 1 && d == 0) r[11:0] = '0;
      else if (idx == 1) begin r[19] = 1'b0; r[1:0] = '0; end
      else if (idx == 2) r[3:0] = '0;
      return r;
   endfunction

   initial begin
      #(200000 * 4);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'h5A17);
      model_clear(0); model_clear(1);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_dir(0);   // R1 R10 reset state
      check_dir(1);

      // R2: slot 1 before tag is ignored, then a clean outbound write (R4 R8)
      new_frame();
      push(0, 1, 20'h0_1000);
      push(0, 0, tag_word(1'b1, 12'b0000_0000_0011, 1'b0, 2'd2));
      push(0, 1, {1'b0, 7'h2A, 12'h000});
      push(0, 2, {16'hBEEF, 4'h0});
      // R11: inbound untouched so far, now an inbound status with request bits (R5)
      push(1, 0, tag_word(1'b1, 12'b0000_0000_0011, 1'b0, 2'd1));
      push(1, 1, {1'b0, 7'h10, 10'b10_1010_0101, 2'b00});
      push(1, 2, {16'h1234, 4'h0});

      // R9: slot 1 of the previous frame does not count; R2 masked slot 1 and index 13
      new_frame();
      push(0, 0, tag_word(1'b0, 12'b0000_0000_0010, 1'b0, 2'd0));
      push(0, 1, {1'b1, 7'h11, 12'h000});
      push(0, 13, 20'hFFFFF);
      push(0, 2, {16'h5555, 4'h0});

      // R3 R4 R6 R7 errors, sticky until frame start (R10)
      new_frame();
      push(0, 0, tag_word(1'b1, 12'hFFF, 1'b1, 2'd3));
      push(0, 1, {1'b1, 7'h33, 12'h001});
      push(0, 2, {16'hA5A5, 4'h8});
      push(0, 5, 20'h12345);
      new_frame();
      // R5 inbound reserved bit 19 and bits 1..0
      push(1, 0, tag_word(1'b1, 12'b0000_0000_0001, 1'b0, 2'd0));
      push(1, 1, {1'b1, 7'h02, 10'h000, 2'b00});
      new_frame();
      push(1, 0, tag_word(1'b1, 12'b0000_0000_0001, 1'b0, 2'd0));
      push(1, 1, {1'b0, 7'h02, 10'h000, 2'b01});

      // random frames
      for (int f = 0; f < 300; f++) begin
         new_frame();
         for (int d = 0; d < 2; d++) begin
            logic [NV-1:0] vm;
            vm = NV'($urandom);
            vm[0] = ($urandom % 4) != 0;
            vm[1] = ($urandom % 4) != 0;
            push(d, 0, tag_word(1'($urandom), vm, ($urandom % 6) == 0, 2'($urandom)));
         end
         for (int p = 0; p < 6; p++) begin
            int d, idx;
            logic [SW-1:0] w;
            d = int'($urandom % 2);
            idx = (p < 4) ? (1 + (p % 2)) : int'($urandom % 16);
            w = SW'($urandom);
            if (($urandom % 4) != 0) w = tidy(d, idx, w);
            push(d, idx, w);
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule